// File: doc/BRIEF.md
# Bus Intercycle Idle and Wait Controller

This block paces external bus cycles for a memory interface whose address space is divided into numbered areas (0, 2, 3, 4, 5 and 6). A requester hands it one access at a time, tagged with an area number and a read/write flag. Before the access it may insert idle cycles, during which no strobe is driven. It then drives the strobe for one cycle plus the area's programmed wait states, and stretches that further while an external wait input is asserted, if that input is enabled.

Idle cycles are only inserted when the new access changes area or reverses direction within the same area. Their count comes from a 2-bit code belonging to the area of the previous access. The wait count comes from a field belonging to the area of the new access. Both are held in two 16-bit control registers on a plain register port. A warm reset input restores the first register and the sequencer, but leaves the wait-state register as it is.

Top module: `bus_idle_wait_ctrl`

## Requirements
- R1: After power-on reset, the register read at `reg_sel`=0 returns 0x3FF3, the one at `reg_sel`=1 returns 0xFFFF, `req_rdy` is high, and `ack`, `cyc_gap` and `cyc_strb` are low.
- R2: Register 0 (`reg_sel`=0) always reads bits 14, 3 and 2 as 0, whatever was written. Its bit 15 enables the wait input, and the idle code of area n sits at bits 2n+1:2n.
- R3: The idle code maps 00 and 01 to one idle cycle, 10 to two and 11 to three. The code used is that of the area of the previous completed access.
- R4: Idle cycles (`cyc_gap` high) precede an access only when its area differs from that of the previous access, or its direction differs within the same area. The first access after power-on reset has no idle cycles.
- R5: Register 1 (`reg_sel`=1) holds the wait counts: area 6 in bits 15:13, area 5 in 12:10, area 4 in 9:7, area 3 in 6:5, area 2 in 4:3 and area 0 in 2:0. With the wait input off, `cyc_strb` stays high for 1+k cycles, where k is the field of the accessed area.
- R6: With bit 15 of register 0 set, `ext_wait` is sampled on the falling clock edge. Each asserted sample taken after the programmed waits have elapsed adds one strobe cycle. Samples taken during the programmed waits or idle cycles have no effect.
- R7: With bit 15 of register 0 clear, `ext_wait` has no effect on the strobe length.
- R8: `ack` is high for the last strobe cycle of every access. `req_rdy` is high in the idle state and during `ack`, so a request taken at `ack` begins its idle or strobe cycles in the very next cycle.
- R9: A low `warm_rst_n` at a clock edge restores register 0 to 0x3FF3, returns the sequencer to idle and clears the access history. Register 1 keeps its value.
- R10: Area numbers 1 and 7 have zero wait states, and as a previous area they count as idle code 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Power-on reset, asynchronous assert, active low |
| warm_rst_n | input | 1 | Synchronous warm reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 idle/enable, 1 wait counts |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data of the selected register |
| req | input | 1 | Access request, taken when `req_rdy` is high |
| req_area | input | 3 | Target area number |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_rdy | output | 1 | Controller can take a request this cycle |
| ack | output | 1 | Last strobe cycle of the current access |
| ext_wait | input | 1 | External wait input |
| cyc_gap | output | 1 | Idle cycle being inserted |
| cyc_strb | output | 1 | Access strobe active |

## Verification
A wrong history register, meaning the wrong remembered area or direction, shows up as a missing or wrongly sized run of `cyc_gap` before the very next access. A wrong counter load shows up as the wrong `cyc_strb` run length, and this is visible at the `ack` that ends that same access. A wait sampler that ignores the enable, or samples too early, changes the strobe length of the access during which `ext_wait` is driven. A warm reset that also clears the wait register shows up in the register read-back immediately afterwards, and again in the strobe lengths of the following accesses.

// File: rtl/bic_pkg.sv
package bic_pkg;
  localparam int REG_W      = 16;
  localparam int AREA_W     = 3;
  localparam int CNT_W      = 3;
  localparam int WAIT_EN_BIT = 15;

  localparam logic [REG_W-1:0] CFG_A_RST  = 16'h3FF3;
  localparam logic [REG_W-1:0] CFG_A_MASK = 16'hBFF3;
  localparam logic [REG_W-1:0] CFG_B_RST  = 16'hFFFF;

  typedef enum logic [1:0] {ST_IDLE, ST_GAP, ST_ACC} seq_st_t;

  // idle cycles owed after an access to 'area' (code 0x -> 1, 10 -> 2, 11 -> 3)
  function automatic logic [CNT_W-1:0] idle_cycles(input logic [REG_W-1:0] a,
                                                   input logic [AREA_W-1:0] area);
    logic [1:0] code;
    case (area)
      3'd0:    code = a[1:0];
      3'd2:    code = a[5:4];
      3'd3:    code = a[7:6];
      3'd4:    code = a[9:8];
      3'd5:    code = a[11:10];
      3'd6:    code = a[13:12];
      default: code = 2'b00;
    endcase
    return code[1] ? CNT_W'(code) : CNT_W'(1);
  endfunction

  function automatic logic [CNT_W-1:0] wait_cycles(input logic [REG_W-1:0] b,
                                                   input logic [AREA_W-1:0] area);
    case (area)
      3'd0:    return b[2:0];
      3'd2:    return {1'b0, b[4:3]};
      3'd3:    return {1'b0, b[6:5]};
      3'd4:    return b[9:7];
      3'd5:    return b[12:10];
      3'd6:    return b[15:13];
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/bic_rst_sync.sv
module bic_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= {sr_q[STAGES-2:0], 1'b1};
  end

  assign rst_s_n = sr_q[STAGES-1];
endmodule

// File: rtl/bic_regs.sv
module bic_regs
  import bic_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             warm_clr,
  input  logic             wr_en,
  input  logic             sel,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  output logic [REG_W-1:0] cfg_a,
  output logic [REG_W-1:0] cfg_b
);
  logic [REG_W-1:0] a_q, a_d, b_q, b_d;

  always_comb begin
    a_d = a_q;
    b_d = b_q;
    if (warm_clr)            a_d = CFG_A_RST;
    else if (wr_en && !sel)  a_d = wdata & CFG_A_MASK;
    if (wr_en && sel)        b_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= CFG_A_RST;
      b_q <= CFG_B_RST;
    end else begin
      a_q <= a_d;
      b_q <= b_d;
    end
  end

  assign cfg_a = a_q;
  assign cfg_b = b_q;
  assign rdata = sel ? b_q : a_q;
endmodule

// File: rtl/bic_wait_smp.sv
module bic_wait_smp (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_wait,
  output logic wait_smp
);
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) wait_smp <= 1'b0;
    else        wait_smp <= ext_wait;
  end
endmodule

// File: rtl/bic_seq.sv
module bic_seq
  import bic_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              warm_clr,
  input  logic [REG_W-1:0]  cfg_a,
  input  logic [REG_W-1:0]  cfg_b,
  input  logic              req,
  input  logic [AREA_W-1:0] req_area,
  input  logic              req_wr,
  input  logic              wait_smp,
  output logic              req_rdy,
  output logic              ack,
  output logic              cyc_gap,
  output logic              cyc_strb
);
  seq_st_t           st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d, wq_q, wq_d;
  logic [AREA_W-1:0] cur_area_q, cur_area_d, last_area_q, last_area_d;
  logic              cur_wr_q, cur_wr_d, last_wr_q, last_wr_d, hist_q, hist_d;

  logic              hold, take, ref_v, ref_wr, need_gap;
  logic [AREA_W-1:0] ref_area;
  logic [CNT_W-1:0]  gap_n, wait_n;
  logic              unused_rsv;

  assign unused_rsv = ^{cfg_a[14], cfg_a[3:2]};

  always_comb begin
    hold     = cfg_a[WAIT_EN_BIT] && wait_smp;
    ack      = (st_q == ST_ACC) && (cnt_q == '0) && !hold;
    req_rdy  = (st_q == ST_IDLE) || ack;
    take     = req && req_rdy;
    ref_area = ack ? cur_area_q : last_area_q;
    ref_wr   = ack ? cur_wr_q   : last_wr_q;
    ref_v    = ack || hist_q;
    need_gap = ref_v && ((req_area != ref_area) || (req_wr != ref_wr));
    gap_n    = idle_cycles(cfg_a, ref_area);
    wait_n   = wait_cycles(cfg_b, req_area);

    st_d        = st_q;
    cnt_d       = cnt_q;
    wq_d        = wq_q;
    cur_area_d  = cur_area_q;
    cur_wr_d    = cur_wr_q;
    last_area_d = last_area_q;
    last_wr_d   = last_wr_q;
    hist_d      = hist_q;

    if (ack) begin
      last_area_d = cur_area_q;
      last_wr_d   = cur_wr_q;
      hist_d      = 1'b1;
    end

    case (st_q)
      ST_GAP: begin
        if (cnt_q == '0) begin
          st_d  = ST_ACC;
          cnt_d = wq_q;
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      ST_ACC: begin
        if (cnt_q != '0) cnt_d = cnt_q - CNT_W'(1);
        else if (ack)    st_d  = ST_IDLE;
      end
      default: ;
    endcase

    if (take) begin
      cur_area_d = req_area;
      cur_wr_d   = req_wr;
      wq_d       = wait_n;
      if (need_gap) begin
        st_d  = ST_GAP;
        cnt_d = gap_n - CNT_W'(1);
      end else begin
        st_d  = ST_ACC;
        cnt_d = wait_n;
      end
    end

    if (warm_clr) begin
      st_d   = ST_IDLE;
      cnt_d  = '0;
      hist_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      cnt_q       <= '0;
      wq_q        <= '0;
      cur_area_q  <= '0;
      cur_wr_q    <= 1'b0;
      last_area_q <= '0;
      last_wr_q   <= 1'b0;
      hist_q      <= 1'b0;
    end else begin
      st_q        <= st_d;
      cnt_q       <= cnt_d;
      wq_q        <= wq_d;
      cur_area_q  <= cur_area_d;
      cur_wr_q    <= cur_wr_d;
      last_area_q <= last_area_d;
      last_wr_q   <= last_wr_d;
      hist_q      <= hist_d;
    end
  end

  assign cyc_gap  = (st_q == ST_GAP);
  assign cyc_strb = (st_q == ST_ACC);
endmodule

// File: rtl/bus_idle_wait_ctrl.sv
module bus_idle_wait_ctrl
  import bic_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              warm_rst_n,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              req,
  input  logic [AREA_W-1:0] req_area,
  input  logic              req_wr,
  output logic              req_rdy,
  output logic              ack,
  input  logic              ext_wait,
  output logic              cyc_gap,
  output logic              cyc_strb
);
  logic             rst_s_n, warm_clr, wait_smp, wait_en;
  logic [REG_W-1:0] cfg_a, cfg_b;

  assign warm_clr = !warm_rst_n;
  assign wait_en  = cfg_a[WAIT_EN_BIT];

  bic_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_s_n(rst_s_n)
  );

  bic_regs u_regs (
    .clk(clk), .rst_n(rst_s_n), .warm_clr(warm_clr), .wr_en(reg_wr),
    .sel(reg_sel), .wdata(reg_wdata), .rdata(reg_rdata),
    .cfg_a(cfg_a), .cfg_b(cfg_b)
  );

  bic_wait_smp u_wsmp (
    .clk(clk), .rst_n(rst_s_n), .ext_wait(ext_wait), .wait_smp(wait_smp)
  );

  bic_seq u_seq (
    .clk(clk), .rst_n(rst_s_n), .warm_clr(warm_clr), .cfg_a(cfg_a),
    .cfg_b(cfg_b), .req(req), .req_area(req_area), .req_wr(req_wr),
    .wait_smp(wait_smp), .req_rdy(req_rdy), .ack(ack),
    .cyc_gap(cyc_gap), .cyc_strb(cyc_strb)
  );
endmodule

// File: rtl/bic_checker.sv
module bic_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        warm_clr,
  input logic        wait_en,
  input logic        req,
  input logic        req_rdy,
  input logic        ack,
  input logic        cyc_gap,
  input logic        cyc_strb,
  input logic        reg_sel,
  input logic [15:0] reg_rdata
);
  logic       warm_d;
  logic [3:0] strb_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      warm_d   <= 1'b0;
      strb_run <= '0;
    end else begin
      warm_d <= warm_clr;
      if (ack || !cyc_strb)     strb_run <= '0;
      else if (strb_run != 4'hF) strb_run <= strb_run + 4'd1;
    end
  end

  // R8: acknowledge only during a strobe cycle
  p_ack_in_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> cyc_strb);

  // R8: strobe released after the final cycle unless a new access is taken
  p_ack_release_r8: assert property (@(posedge clk) disable iff (!rst_n || warm_clr)
    (ack && !(req && req_rdy)) |=> !cyc_strb);

  // R3: an idle run always ends in a strobe
  p_gap_ends_strb_r3: assert property (@(posedge clk) disable iff (!rst_n || warm_clr || warm_d)
    $fell(cyc_gap) |-> cyc_strb);

  // R4: idle and strobe never together
  p_gap_strb_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(cyc_gap && cyc_strb));

  // R2: reserved bits of register 0 read zero
  p_rsv_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_sel |-> (reg_rdata[14] == 1'b0 && reg_rdata[3:2] == 2'b00));

  // R7: with wait input off, a strobe never exceeds 1 + 7 cycles
  p_wait_bound_r7: assert property (@(posedge clk) disable iff (!rst_n || warm_clr)
    (!wait_en && cyc_strb) |-> (strb_run < 4'd8));
endmodule

bind bus_idle_wait_ctrl bic_checker u_chk (
  .clk(clk), .rst_n(rst_s_n), .warm_clr(warm_clr), .wait_en(wait_en),
  .req(req), .req_rdy(req_rdy), .ack(ack), .cyc_gap(cyc_gap),
  .cyc_strb(cyc_strb), .reg_sel(reg_sel), .reg_rdata(reg_rdata)
);

// File: tb/test_bus_idle_wait_ctrl.sv
module test_bus_idle_wait_ctrl;
  logic        clk = 1'b0;
  logic        rst_n, warm_rst_n, reg_wr, reg_sel, req, req_wr, ext_wait;
  logic [15:0] reg_wdata, reg_rdata;
  logic [2:0]  req_area;
  logic        req_rdy, ack, cyc_gap, cyc_strb;

  always #10 clk = ~clk;

  bus_idle_wait_ctrl i_bus_idle_wait_ctrl (
    .clk(clk), .rst_n(rst_n), .warm_rst_n(warm_rst_n), .reg_wr(reg_wr),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .req(req), .req_area(req_area), .req_wr(req_wr), .req_rdy(req_rdy),
    .ack(ack), .ext_wait(ext_wait), .cyc_gap(cyc_gap), .cyc_strb(cyc_strb)
  );

  typedef struct { int gap; int strb; int quiet; string tag; } exp_t;
  exp_t expq[$];

  int errors = 0, checks = 0;
  logic [15:0] sh_a = 16'h3FF3, sh_b = 16'hFFFF;
  int  last_area = 0;
  bit  last_wr = 0, have_last = 0, mon_on = 0, wait_on = 0;
  int  wait_len = 0, strb_cnt = 0, gap_cnt = 0, quiet_cnt = 0;

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int idle_of(int area);
    logic [1:0] c;
    case (area)
      0: c = sh_a[1:0];   2: c = sh_a[5:4];   3: c = sh_a[7:6];
      4: c = sh_a[9:8];   5: c = sh_a[11:10]; 6: c = sh_a[13:12];
      default: c = 2'b00;
    endcase
    return (c == 2'b11) ? 3 : (c == 2'b10) ? 2 : 1;
  endfunction

  function automatic int wait_of(int area);
    case (area)
      0: return int'(sh_b[2:0]);   2: return int'(sh_b[4:3]);
      3: return int'(sh_b[6:5]);   4: return int'(sh_b[9:7]);
      5: return int'(sh_b[12:10]); 6: return int'(sh_b[15:13]);
      default: return 0;
    endcase
  endfunction

  // call at posedge+1
  task automatic reg_write(bit sel, logic [15:0] d);
    reg_wr = 1; reg_sel = sel; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 0;
    if (sel) sh_b = d; else sh_a = d & 16'hBFF3;
  endtask

  task automatic reg_check(bit sel, logic [15:0] exp, string tag);
    reg_sel = sel; #2;
    chk(tag, sel ? "reg1" : "reg0", int'(reg_rdata), int'(exp));
  endtask

  // driver: call at posedge+1; pushes the expected item and holds req until taken
  task automatic issue(int area, bit wr, int ext, int quiet_exp, string tag);
    exp_t e;
    e.gap   = (have_last && (area != last_area || wr != last_wr)) ? idle_of(last_area) : 0;
    e.strb  = 1 + wait_of(area) + ext;
    e.quiet = quiet_exp;
    e.tag   = tag;
    expq.push_back(e);
    last_area = area; last_wr = wr; have_last = 1;
    req = 1; req_area = area[2:0]; req_wr = wr;
    do begin @(negedge clk); #5; end while (!req_rdy);
    @(posedge clk); #1;
    req = 0;
  endtask

  task automatic drain();
    do @(posedge clk); while (expq.size() != 0);
    wait_on = 0;
    #1;
  endtask

  task automatic single(int area, bit wr, int ext, int drive_len, string tag);
    wait_len = drive_len;
    wait_on  = 1;
    issue(area, wr, ext, -1, tag);
    drain();
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk); #5;
      if (mon_on) begin
        if (cyc_strb) strb_cnt++;
        if (cyc_gap)  gap_cnt++;
        if (!cyc_strb && !cyc_gap) quiet_cnt++;
        if (ack) begin
          if (expq.size() == 0) begin
            chk("R8", "unexpected ack", 1, 0);
          end else begin
            exp_t e;
            e = expq.pop_front();
            chk(e.tag, "idle cycles", gap_cnt, e.gap);
            chk(e.tag, "strobe cycles", strb_cnt, e.strb);
            if (e.quiet >= 0) chk("R8", "cycles between accesses", quiet_cnt, e.quiet);
          end
          strb_cnt = 0; gap_cnt = 0; quiet_cnt = 0;
        end
      end
    end
  end

  // wait input driver: asserted while fewer than wait_len strobe cycles have passed
  initial begin
    ext_wait = 0;
    forever begin
      @(posedge clk); #1;
      ext_wait = wait_on && (strb_cnt < wait_len);
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 0; warm_rst_n = 1; reg_wr = 0; reg_sel = 0; reg_wdata = '0;
    req = 0; req_area = '0; req_wr = 0;
    repeat (3) @(posedge clk); #1;
    rst_n = 1;
    repeat (4) @(posedge clk); #1;
    mon_on = 1;

    // R1 reset state
    reg_check(0, 16'h3FF3, "R1");
    reg_check(1, 16'hFFFF, "R1");
    chk("R1", "req_rdy", int'(req_rdy), 1);
    chk("R1", "ack", int'(ack), 0);
    chk("R1", "cyc_gap|cyc_strb", int'(cyc_gap | cyc_strb), 0);

    // R2 reserved bits
    @(posedge clk); #1;
    reg_write(0, 16'hFFFF);
    reg_check(0, 16'hBFF3, "R2");
    @(posedge clk); #1;
    reg_write(0, 16'h1B9C);   // idle codes: a0=00 a2=01 a3=10 a4=11 a5=10 a6=01
    reg_check(0, 16'h1B90, "R2");
    @(posedge clk); #1;
    reg_write(1, 16'hA86C);   // waits: a6=5 a5=2 a4=0 a3=3 a2=1 a0=4
    reg_check(1, 16'hA86C, "R5");

    // back-to-back accesses
    @(posedge clk); #1;
    issue(0, 0, 0, -1, "R4");  // first: no idle
    issue(0, 0, 0,  0, "R4");  // same area/dir: no idle
    issue(0, 1, 0,  0, "R3");  // dir change, code 00 -> 1
    issue(2, 1, 0,  0, "R5");  // area change, wait 1
    issue(3, 1, 0,  0, "R3");  // code 01 -> 1
    issue(4, 0, 0,  0, "R3");  // code 10 -> 2
    issue(5, 0, 0,  0, "R3");  // code 11 -> 3
    issue(6, 0, 0,  0, "R5");  // code 10 -> 2, wait 5
    issue(6, 1, 0,  0, "R4");  // dir change in area 6
    issue(7, 1, 0,  0, "R10"); // unmapped area: no waits
    issue(0, 1, 0,  0, "R10"); // previous unmapped: one idle
    drain();

    // R6 wait input enabled
    @(posedge clk); #1;
    reg_write(0, 16'h9B90);
    single(4, 0, 3, wait_of(4) + 3, "R6");
    @(posedge clk); #1;
    single(2, 0, 2, wait_of(2) + 2, "R6");

    // R7 wait input disabled, held high throughout
    @(posedge clk); #1;
    reg_write(0, 16'h1B90);
    single(2, 0, 0, 100, "R7");

    // R9 warm reset
    @(posedge clk); #1;
    reg_write(0, 16'h0000);
    warm_rst_n = 0;
    @(posedge clk); #1;
    warm_rst_n = 1;
    sh_a = 16'h3FF3; have_last = 0;
    reg_check(0, 16'h3FF3, "R9");
    reg_check(1, 16'hA86C, "R9");
    @(posedge clk); #1;
    issue(5, 1, 0, -1, "R9");   // history cleared: no idle
    issue(6, 1, 0,  0, "R9");   // area 5 code back to 11 -> 3 idles
    drain();

    repeat (3) @(posedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule